// File: doc/BRIEF.md
# Dual-Half Eight-Lane Pixel Distributor

This block takes a raster pixel stream, one 10-bit pixel per accepted cycle, and hands each active line out over eight parallel pixel lanes. The line is cut into a left half and a right half. Lanes 1 to 4 carry only left-half pixels and lanes 5 to 8 carry only right-half pixels. Within each half, the lane pairs (1,2), (3,4), (5,6) and (7,8) split even-indexed pixels from odd-indexed ones. Each output cycle carries one group of four consecutive pixels from each half. A full output line therefore takes LINE_W/8 cycles, which is one eighth of the cycles the input needs to write it.

A ping-pong line memory sits between the two sides. One bank fills with the incoming line while the other is read out. Both halves of a line leave on the same output cycles. The memory is split into one bank per lane, so that a group of eight pixels can be read in a single cycle.

Top module: `px8_distributor`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_sol and out_sof are low.
- R2: On the k-th output cycle of a line, lanes 1, 2, 3 and 4 (out_lanes bits [9:0], [19:10], [29:20], [39:30]) carry left-half pixels 4k, 4k+1, 4k+2 and 4k+3.
- R3: On the same cycle, lanes 5 to 8 (out_lanes bits [49:40] up to [79:70]) carry pixels LINE_W/2+4k up to LINE_W/2+4k+3.
- R4: Once the last of LINE_W pixels is accepted, out_valid rises right after the second following clock edge and stays high for exactly LINE_W/8 consecutive cycles.
- R5: out_sol is high on the first group of each output line and low on every other cycle.
- R6: out_sof is high together with out_sol only when the line's first pixel arrived with in_sof high.
- R7: A cycle with in_valid low neither writes a pixel nor advances the pixel index.
- R8: A pixel with in_sol high always starts a new line at index 0, and a partly received line is dropped without any output.
- R9: Valid pixels that follow the LINE_W-th pixel, before the next in_sol, are ignored.
- R10: Valid pixels that arrive while no line is open (after reset, with no in_sol yet) are ignored.
- R11: Lines sent back to back, with no idle cycle between them, all come out intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input and output sides |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_sof | input | 1 | Marks the first line of a frame; only taken together with in_sol |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output group present this cycle |
| out_sol | output | 1 | First group of an output line |
| out_sof | output | 1 | First group of the first line of a frame |
| out_lanes | output | 8*PIX_W | Lane n (1 to 8) at bits [n*PIX_W-1 : (n-1)*PIX_W] |

## Verification
The hardest case to reach from the ports is writing one bank while the other bank is being read: a new line filling up during the short output burst of the line before it. The stimulus reaches it by sending three lines with no idle cycle between them. Each line's output burst then runs while the first pixels of the next line are written into the other bank. Further cases are a line aborted by an early in_sol and then restarted, surplus pixels after a full line, and stray pixels before any line is open. A cycle-level model in the bench keeps its own line copies and predicts every lane value and marker on every cycle.

// File: rtl/px8_pkg.sv
package px8_pkg;
  // Lane layout shared by the distributor blocks.
  localparam int NUM_LANES      = 8;
  localparam int LANES_PER_HALF = NUM_LANES / 2;
  localparam int SLOT_W         = $clog2(LANES_PER_HALF);
endpackage

// File: rtl/px8_wr_ctrl.sv
// Input side: tracks the pixel index, maps each pixel to a lane bank and
// address, and hands a completed line over to the read side.
module px8_wr_ctrl
  import px8_pkg::*;
#(
  parameter int LINE_W = 4096,
  parameter int PIX_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic                       in_sof,
  input  logic [PIX_W-1:0]           in_pix,
  output logic [NUM_LANES-1:0]       wr_en,
  output logic [$clog2(LINE_W/8):0]  wr_addr,
  output logic [PIX_W-1:0]           wr_data,
  output logic                       hand_off,
  output logic                       hand_bank,
  output logic                       hand_sof
);
  localparam int IDX_W  = $clog2(LINE_W);
  localparam int HALF_W = LINE_W / 2;
  localparam int GRP_W  = $clog2(LINE_W / 8);

  logic             open_q, bank_q, sof_q;
  logic [IDX_W-1:0] idx_q, cur_idx, pos;
  logic             start, accept, in_right, last, cur_sof;
  logic [GRP_W-1:0] grp;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    start    = in_valid && in_sol;
    accept   = in_valid && (start || open_q);
    cur_idx  = start ? '0 : idx_q;
    cur_sof  = start ? in_sof : sof_q;
    in_right = (cur_idx >= IDX_W'(HALF_W));
    pos      = in_right ? (cur_idx - IDX_W'(HALF_W)) : cur_idx;
    slot     = pos[SLOT_W-1:0];
    grp      = GRP_W'(pos >> SLOT_W);
    last     = accept && (cur_idx == IDX_W'(LINE_W - 1));
    wr_en    = '0;
    if (accept) wr_en[{in_right, slot}] = 1'b1;
    wr_addr   = {bank_q, grp};
    wr_data   = in_pix;
    hand_off  = last;
    hand_bank = bank_q;
    hand_sof  = cur_sof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      bank_q <= 1'b0;
      sof_q  <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      if (last) begin
        open_q <= 1'b0;
        bank_q <= ~bank_q;
        idx_q  <= '0;
      end else begin
        open_q <= 1'b1;
        idx_q  <= cur_idx + 1'b1;
        sof_q  <= cur_sof;
      end
    end
  end
endmodule

// File: rtl/px8_lane_ram.sv
// One lane bank: simple dual-port memory with registered read.
module px8_lane_ram #(
  parameter int PIX_W = 10,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/px8_rd_ctrl.sv
// Output side: walks the groups of a handed-over line and registers the
// line and frame markers to match the memory read latency.
module px8_rd_ctrl #(
  parameter int LINE_W = 4096
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hand_off,
  input  logic                      hand_bank,
  input  logic                      hand_sof,
  output logic                      rd_en,
  output logic [$clog2(LINE_W/8):0] rd_addr,
  output logic                      out_valid,
  output logic                      out_sol,
  output logic                      out_sof
);
  localparam int GRP   = LINE_W / 8;
  localparam int GRP_W = $clog2(GRP);

  logic             act_q, bank_q, sof_q;
  logic [GRP_W-1:0] grp_q;
  logic             first;

  always_comb begin
    first   = act_q && (grp_q == '0);
    rd_en   = act_q;
    rd_addr = {bank_q, grp_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      bank_q <= 1'b0;
      sof_q  <= 1'b0;
      grp_q  <= '0;
    end else if (hand_off) begin
      act_q  <= 1'b1;
      bank_q <= hand_bank;
      sof_q  <= hand_sof;
      grp_q  <= '0;
    end else if (act_q) begin
      if (grp_q == GRP_W'(GRP - 1)) act_q <= 1'b0;
      grp_q <= grp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      out_valid <= act_q;
      out_sol   <= first;
      out_sof   <= first && sof_q;
    end
  end
endmodule

// File: rtl/px8_distributor.sv
// Top: write control, eight lane banks, read control.
module px8_distributor
  import px8_pkg::*;
#(
  parameter int LINE_W = 4096,
  parameter int PIX_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic                       in_sof,
  input  logic [PIX_W-1:0]           in_pix,
  output logic                       out_valid,
  output logic                       out_sol,
  output logic                       out_sof,
  output logic [NUM_LANES*PIX_W-1:0] out_lanes
);
  localparam int AW = $clog2(LINE_W / 8) + 1;

  logic [NUM_LANES-1:0] wr_en;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic [PIX_W-1:0]     wr_data;
  logic                 hand_off, hand_bank, hand_sof, rd_en;

  px8_wr_ctrl #(.LINE_W(LINE_W), .PIX_W(PIX_W)) wr_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hand_off(hand_off), .hand_bank(hand_bank),
    .hand_sof(hand_sof)
  );

  px8_rd_ctrl #(.LINE_W(LINE_W)) rd_i (
    .clk(clk), .rst(rst), .hand_off(hand_off), .hand_bank(hand_bank),
    .hand_sof(hand_sof), .rd_en(rd_en), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    px8_lane_ram #(.PIX_W(PIX_W), .AW(AW)) ram_i (
      .clk(clk), .we(wr_en[k]), .waddr(wr_addr), .wdata(wr_data),
      .re(rd_en), .raddr(rd_addr), .rdata(out_lanes[k*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/px8_checker.sv
// Temporal checks on the distributor's output markers.
module px8_checker #(
  parameter int GRP = 512
) (
  input logic clk,
  input logic rst,
  input logic hand_off,
  input logic out_valid,
  input logic out_sol,
  input logic out_sof
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 0;
    else     run_q <= out_valid ? run_q + 1 : 0;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_sol && !out_sof));

  p_start_follows_line_r4: assert property (@(posedge clk) disable iff (rst)
    hand_off |=> ##1 (out_valid && out_sol));

  p_burst_cap_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run_q < GRP));

  p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && run_q != 0) |-> (run_q == GRP));

  p_sol_first_r5: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> (out_valid && run_q == 0));

  p_sof_on_sol_r6: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_sol);
endmodule

bind px8_distributor px8_checker #(.GRP(LINE_W / 8)) chk_i (
  .clk(clk), .rst(rst), .hand_off(hand_off), .out_valid(out_valid),
  .out_sol(out_sol), .out_sof(out_sof)
);

// File: tb/px8_distributor_tb_top.sv
module px8_distributor_tb_top;
  localparam int LW = 64;
  localparam int PW = 10;
  localparam int G  = LW / 8;
  localparam int HW = LW / 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic out_valid, out_sol, out_sof;
  logic [8*PW-1:0] out_lanes;

  int checks = 0, errors = 0, pix_ctr = 0, obs_groups = 0;
  bit finished = 0;
  string scen = "R1";

  always #5 clk = ~clk;

  px8_distributor #(.LINE_W(LW), .PIX_W(PW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid),
    .out_sol(out_sol), .out_sof(out_sof), .out_lanes(out_lanes)
  );

  // Reference model: line copies held in integer arrays.
  int m_cur[LW];
  int m_buf[LW];
  bit m_open = 0, m_cur_sof = 0, m_act = 0, m_sof = 0;
  int m_idx = 0, m_grp = 0;
  bit e_valid = 0, e_sol = 0, e_sof = 0;
  int e_lane[8];

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_idx = 0; m_act = 0; m_grp = 0;
      e_valid = 0; e_sol = 0; e_sof = 0;
    end else begin
      e_valid = m_act;
      e_sol   = m_act && (m_grp == 0);
      e_sof   = e_sol && m_sof;
      if (m_act) begin
        for (int l = 0; l < 4; l++) begin
          e_lane[l]   = m_buf[4*m_grp + l];
          e_lane[l+4] = m_buf[HW + 4*m_grp + l];
        end
        m_grp++;
        if (m_grp == G) m_act = 0;
      end
      if (in_valid) begin
        if (in_sol) begin m_open = 1; m_idx = 0; m_cur_sof = in_sof; end
        if (m_open) begin
          m_cur[m_idx] = int'(in_pix);
          if (m_idx == LW - 1) begin
            m_buf = m_cur; m_act = 1; m_grp = 0; m_sof = m_cur_sof; m_open = 0;
          end else m_idx++;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d", req, scen, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(out_valid === e_valid, "R4", "out_valid", int'(out_valid), int'(e_valid));
      chk(out_sol === e_sol, "R5", "out_sol", int'(out_sol), int'(e_sol));
      chk(out_sof === e_sof, "R6", "out_sof", int'(out_sof), int'(e_sof));
      if (e_valid) begin
        for (int l = 0; l < 8; l++) begin
          chk(out_lanes[l*PW +: PW] === PW'(e_lane[l]), (l < 4) ? "R2" : "R3",
              $sformatf("lane %0d", l + 1), int'(out_lanes[l*PW +: PW]), e_lane[l]);
        end
      end
      if (out_valid === 1'b1) obs_groups++;
    end
  end

  task automatic drive_pix(bit sol, bit sof);
    in_valid = 1'b1; in_sol = sol; in_sof = sof;
    in_pix = PW'(pix_ctr % 1024);
    pix_ctr++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_line(int n, bit sof, int gap);
    for (int i = 0; i < n; i++) begin
      drive_pix(i == 0, sof && (i == 0));
      if (gap > 0 && (i % gap) == gap - 1) idle(1);
    end
  endtask

  task automatic expect_groups(int n, string req);
    idle(G + 4);
    chk(obs_groups == n, req, "group count", obs_groups, n);
    obs_groups = 0;
  endtask

  task automatic report();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_sol === 1'b0 && out_sof === 1'b0,
        "R1", "markers in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_sol === 1'b0 && out_sof === 1'b0,
        "R1", "markers after reset", int'(out_valid), 0);
    obs_groups = 0;

    scen = "R10";  // stray pixels with no open line
    for (int i = 0; i < 10; i++) drive_pix(1'b0, i == 3);
    expect_groups(0, "R10");

    scen = "R11";  // frame of three back-to-back lines
    send_line(LW, 1'b1, 0);
    send_line(LW, 1'b0, 0);
    send_line(LW, 1'b0, 0);
    expect_groups(3 * G, "R11");

    scen = "R7";   // gaps in in_valid
    send_line(LW, 1'b0, 3);
    expect_groups(G, "R7");

    scen = "R8";   // aborted partial line, then a full one
    send_line(20, 1'b0, 0);
    send_line(LW, 1'b0, 0);
    expect_groups(G, "R8");

    scen = "R9";   // surplus pixels, then a new frame
    send_line(LW, 1'b0, 0);
    for (int i = 0; i < 10; i++) drive_pix(1'b0, 1'b0);
    send_line(LW, 1'b1, 0);
    expect_groups(2 * G, "R9");

    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (%s): actual timeout expected completion", scen);
    report();
  end
endmodule